// File: doc/BRIEF.md
# SPI Controller Interrupt Status Aggregator

This block keeps the interrupt state for a four-channel serial peripheral controller and condenses it into one level-sensitive interrupt line. Every channel sends a one-cycle strobe when its transmit holding register drains and another when its receive register fills. Each strobe sets a sticky bit in a 17-bit status register. Software acknowledges an event by writing a one to the bit, and chooses which bits may raise the interrupt through an enable register of the same shape.

For bring-up and production test, a mode register and a test register work together so that software can drive every implemented status bit to one at once. While that test combination is armed, writes that would acknowledge bits are ignored. Register writes arrive on a simple one-cycle write port with a two-bit selector. All four registers are visible on output ports, so a neighbouring bus decoder can return them on reads.

Top module: `spi_irq_agg`

## Requirements
- R1: While `rst_ni` is low and after its release, status and enable read 0, test reads 0, mode reads 4, and `irq_o` is 0.
- R2: A `tx_empty_set_i[n]` strobe sets status bit 4n, and an `rx_full_set_i[n]` strobe sets status bit 4n+2, in the clock edge that samples it. The bit stays set until it is cleared.
- R3: A write with `wr_sel_i`=0 (status) clears every status bit whose data bit is one and leaves every other bit unchanged, unless R4 applies.
- R4: A status write is ignored while mode bit 3 and test bit 11 are both one.
- R5: A write with `wr_sel_i`=2 (test) that has data bit 11 set, made while mode bit 3 is already one, sets all status bits in mask 0x1777F.
- R6: A write with `wr_sel_i`=3 (mode) that has data bit 3 set, made while test bit 11 is already one, sets all status bits in mask 0x1777F.
- R7: A write with `wr_sel_i`=1 (enable) stores the data ANDed with 0x1777F. Status and enable bits outside 0x1777F always read 0.
- R8: When a set strobe and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq_o` is a registered signal. After each clock edge it shows whether status AND enable was nonzero just before that edge, so it lags a register change by one cycle.
- R10: A test write stores data bits 11:0, and a mode write stores data bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 status, 1 enable, 2 test, 3 mode |
| wr_data_i | input | 17 | Write data |
| tx_empty_set_i | input | 4 | Per-channel transmit-empty event strobes |
| rx_full_set_i | input | 4 | Per-channel receive-full event strobes |
| status_o | output | 17 | Interrupt status register |
| enable_o | output | 17 | Interrupt enable register |
| test_o | output | 12 | Test register |
| mode_o | output | 4 | Module mode register |
| irq_o | output | 1 | Level interrupt request |

## Verification
Every register is visible on a port, so a wrong status, enable, test or mode bit appears on `status_o`, `enable_o`, `test_o` or `mode_o` at the first sample after the edge that should have written it. A fault in the interrupt path appears on `irq_o` one cycle later. A wrongly placed channel bit, a lost event under a simultaneous clear, or a failed force is therefore visible within two cycles of the stimulus. A test-mode block that leaks through shows up as a status bit dropping when it should not.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_TEST   = 2'd2,
    SEL_MODE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_event_map.sv
module irq_event_map #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned STAT_W = 17,
  parameter int unsigned STRIDE = 4,
  parameter int unsigned TX_OFS = 0,
  parameter int unsigned RX_OFS = 2
) (
  input  logic [NCH-1:0]    tx_set_i,
  input  logic [NCH-1:0]    rx_set_i,
  output logic [STAT_W-1:0] set_o
);
  logic [STAT_W-1:0] chan_v [NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int unsigned TXB = ch * STRIDE + TX_OFS;
    localparam int unsigned RXB = ch * STRIDE + RX_OFS;
    always_comb begin
      chan_v[ch]      = '0;
      chan_v[ch][TXB] = tx_set_i[ch];
      chan_v[ch][RXB] = rx_set_i[ch];
    end
  end

  always_comb begin
    set_o = '0;
    for (int ch = 0; ch < NCH; ch++) set_o = set_o | chan_v[ch];
  end
endmodule

// File: rtl/irq_test_ctrl.sv
module irq_test_ctrl
  import spi_irq_pkg::*;
#(
  parameter int unsigned          TEST_W     = 12,
  parameter int unsigned          MODE_W     = 4,
  parameter int unsigned          TEST_BIT   = 11,
  parameter int unsigned          MODE_BIT   = 3,
  parameter logic [MODE_W-1:0]    MODE_RST   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_sel_e          wr_sel_i,
  input  logic [TEST_W-1:0] test_data_i,
  input  logic [MODE_W-1:0] mode_data_i,
  output logic [TEST_W-1:0] test_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              force_o,
  output logic              clr_block_o
);
  logic [TEST_W-1:0] test_q;
  logic [MODE_W-1:0] mode_q;
  logic              wr_test, wr_mode;

  assign wr_test = wr_en_i && (wr_sel_i == SEL_TEST);
  assign wr_mode = wr_en_i && (wr_sel_i == SEL_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      test_q <= '0;
      mode_q <= MODE_RST;
    end else begin
      if (wr_test) test_q <= test_data_i;
      if (wr_mode) mode_q <= mode_data_i;
    end
  end

  // force needs the new bit in this write and the partner bit already stored
  assign force_o = (wr_test && test_data_i[TEST_BIT] && mode_q[MODE_BIT]) ||
                   (wr_mode && mode_data_i[MODE_BIT] && test_q[TEST_BIT]);
  assign clr_block_o = mode_q[MODE_BIT] && test_q[TEST_BIT];

  assign test_o = test_q;
  assign mode_o = mode_q;

  AST_MODE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mode |=> $stable(mode_q)) else $error("mode changed without write"); // R10
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned        STAT_W = 17,
  parameter logic [STAT_W-1:0]  MASK   = 17'h1777F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] clr_i,
  input  logic              force_i,
  output logic [STAT_W-1:0] status_o
);
  logic [STAT_W-1:0] status_q, status_d;

  always_comb begin
    // set is applied after clear so an event is never lost
    status_d = (status_q & ~clr_i) | set_i;
    if (force_i) status_d = MASK;
    status_d = status_d & MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign status_o = status_q;

  AST_FORCE_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> (status_q == MASK)) else $error("force incomplete"); // R5
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i))) else $error("event lost"); // R8
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i != '0) && (set_i == '0) && !force_i) |=> ((status_q & $past(clr_i)) == '0))
    else $error("clear failed"); // R3
endmodule

// File: rtl/irq_enable_out.sv
module irq_enable_out #(
  parameter int unsigned        STAT_W = 17,
  parameter logic [STAT_W-1:0]  MASK   = 17'h1777F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] data_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [STAT_W-1:0] enable_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] enable_q;
  logic              irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_i) enable_q <= data_i & MASK;
      irq_q <= |(status_i & enable_q);
    end
  end

  assign enable_o = enable_q;
  assign irq_o    = irq_q;

  AST_EN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(enable_q)) else $error("enable drift"); // R7
endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
  import spi_irq_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned STAT_W = 17,
  parameter int unsigned TEST_W = 12,
  parameter int unsigned MODE_W = 4,
  parameter logic [STAT_W-1:0] MASK = 17'h1777F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [STAT_W-1:0] wr_data_i,
  input  logic [NCH-1:0]    tx_empty_set_i,
  input  logic [NCH-1:0]    rx_full_set_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] enable_o,
  output logic [TEST_W-1:0] test_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              irq_o
);
  localparam int unsigned TEST_BIT = TEST_W - 1;
  localparam int unsigned MODE_BIT = MODE_W - 1;

  reg_sel_e          sel;
  logic [STAT_W-1:0] set_vec, clr_vec;
  logic              force_all, clr_block, wr_status, wr_enable;

  assign sel       = reg_sel_e'(wr_sel_i);
  assign wr_status = wr_en_i && (sel == SEL_STATUS);
  assign wr_enable = wr_en_i && (sel == SEL_ENABLE);
  assign clr_vec   = (wr_status && !clr_block) ? wr_data_i : '0;

  irq_event_map #(.NCH(NCH), .STAT_W(STAT_W)) i_event_map (
    .tx_set_i (tx_empty_set_i),
    .rx_set_i (rx_full_set_i),
    .set_o    (set_vec)
  );

  irq_test_ctrl #(
    .TEST_W(TEST_W), .MODE_W(MODE_W), .TEST_BIT(TEST_BIT), .MODE_BIT(MODE_BIT),
    .MODE_RST(MODE_W'(4))
  ) i_test_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (sel),
    .test_data_i (wr_data_i[TEST_W-1:0]),
    .mode_data_i (wr_data_i[MODE_W-1:0]),
    .test_o      (test_o),
    .mode_o      (mode_o),
    .force_o     (force_all),
    .clr_block_o (clr_block)
  );

  irq_status_reg #(.STAT_W(STAT_W), .MASK(MASK)) i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .force_i  (force_all),
    .status_o (status_o)
  );

  irq_enable_out #(.STAT_W(STAT_W), .MASK(MASK)) i_enable (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_enable),
    .data_i   (wr_data_i),
    .status_i (status_o),
    .enable_o (enable_o),
    .irq_o    (irq_o)
  );

  AST_CLEAR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status && mode_o[MODE_BIT] && test_o[TEST_BIT]) |=> (($past(status_o) & ~status_o) == '0))
    else $error("blocked clear took effect"); // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past((status_o & enable_o) != '0)) else $error("irq without cause"); // R9
  AST_TX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_set_i[0] |=> status_o[0]) else $error("tx event lost"); // R2
endmodule

// File: tb/test_spi_irq_agg.sv
module test_spi_irq_agg;
  localparam int CLK_PERIOD = 10;
  localparam logic [16:0] MASK = 17'h1777F;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [16:0] wr_data = '0;
  logic [3:0]  tx_set = '0, rx_set = '0;
  logic [16:0] status, enable;
  logic [11:0] test;
  logic [3:0]  mode;
  logic        irq;

  logic [16:0] m_st, m_en;
  logic [11:0] m_test;
  logic [3:0]  m_mode;
  logic        m_irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_agg i_spi_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .tx_empty_set_i(tx_set), .rx_full_set_i(rx_set),
    .status_o(status), .enable_o(enable), .test_o(test), .mode_o(mode), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] ev_vec(logic [3:0] tx, logic [3:0] rx);
    logic [16:0] v = '0;
    for (int n = 0; n < 4; n++) begin
      v[4*n]   = tx[n];
      v[4*n+2] = rx[n];
    end
    return v;
  endfunction

  task automatic compare_all();
    check("R2/R3/R4 status", 32'(status), 32'(m_st));
    check("R7 enable", 32'(enable), 32'(m_en));
    check("R10 test", 32'(test), 32'(m_test));
    check("R10 mode", 32'(mode), 32'(m_mode));
    check("R9 irq", 32'(irq), 32'(m_irq));
  endtask

  // drive at a negedge, model the edge, compare at the next negedge
  task automatic step(logic we, logic [1:0] sel, logic [16:0] d, logic [3:0] tx, logic [3:0] rx);
    logic [16:0] nst;
    logic        frc;
    wr_en = we; wr_sel = sel; wr_data = d; tx_set = tx; rx_set = rx;
    nst = m_st;
    frc = 1'b0;
    if (we && sel == 2'd0 && !(m_mode[3] && m_test[11])) nst = nst & ~d;
    if (we && sel == 2'd2 && d[11] && m_mode[3]) frc = 1'b1;
    if (we && sel == 2'd3 && d[3] && m_test[11]) frc = 1'b1;
    nst = nst | ev_vec(tx, rx);
    if (frc) nst = MASK;
    @(posedge clk);
    m_irq = |(m_st & m_en);
    m_st  = nst & MASK;
    if (we && sel == 2'd1) m_en = d & MASK;
    if (we && sel == 2'd2) m_test = d[11:0];
    if (we && sel == 2'd3) m_mode = d[3:0];
    @(negedge clk);
    wr_en = 1'b0; tx_set = '0; rx_set = '0;
    compare_all();
  endtask

  task automatic idle();
    step(1'b0, 2'd0, '0, '0, '0);
  endtask

  initial begin
    m_st = '0; m_en = '0; m_test = '0; m_mode = 4'd4; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 status in reset", 32'(status), 0);
    check("R1 mode in reset", 32'(mode), 4);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status", 32'(status), 0);
    check("R1 enable", 32'(enable), 0);
    check("R1 test", 32'(test), 0);
    check("R1 mode", 32'(mode), 4);
    check("R1 irq", 32'(irq), 0);

    // R2 bit placement per channel
    for (int n = 0; n < 4; n++) begin
      step(1'b0, 2'd0, '0, 4'(1 << n), '0);
      check("R2 tx bit", 32'(status[4*n]), 1);
      step(1'b0, 2'd0, '0, '0, 4'(1 << n));
      check("R2 rx bit", 32'(status[4*n+2]), 1);
    end
    idle();
    check("R2 sticky", 32'(status), 32'h5555);

    // R7 enable masking, R9 one-cycle lag
    step(1'b1, 2'd1, 17'h1FFFF, '0, '0);
    check("R7 enable mask", 32'(enable), 32'h1777F);
    check("R9 irq lag", 32'(irq), 0);
    idle();
    check("R9 irq set", 32'(irq), 1);

    // R3 clear by ones
    step(1'b1, 2'd0, 17'h0105, '0, '0);
    check("R3 partial clear", 32'(status), 32'h5450);
    step(1'b1, 2'd0, 17'h1FFFF, '0, '0);
    check("R3 full clear", 32'(status), 0);
    check("R9 irq still high", 32'(irq), 1);
    idle();
    check("R9 irq drop", 32'(irq), 0);

    // R8 set beats clear
    step(1'b0, 2'd0, '0, 4'h2, '0);
    step(1'b1, 2'd0, 17'h0010, 4'h2, '0);
    check("R8 set wins", 32'(status[4]), 1);

    // R10 field widths
    step(1'b1, 2'd2, 17'h1F7FF, '0, '0);
    check("R10 test low bits", 32'(test), 32'h7FF);
    step(1'b1, 2'd3, 17'h000F0, '0, '0);
    check("R10 mode low bits", 32'(mode), 0);

    // R5 force via test write with mode bit 3 already set
    step(1'b1, 2'd3, 17'h8, '0, '0);
    check("R5 no force yet", 32'(status), 32'h10);
    step(1'b1, 2'd2, 17'h800, '0, '0);
    check("R5 force", 32'(status), 32'h1777F);
    // R4 clear blocked
    step(1'b1, 2'd0, 17'h1FFFF, '0, '0);
    check("R4 clear ignored", 32'(status), 32'h1777F);

    // R6 force via mode write with test bit 11 already set
    step(1'b1, 2'd3, 17'h0, '0, '0);
    step(1'b1, 2'd0, 17'h1FFFF, '0, '0);
    check("R4 unblocked clear", 32'(status), 0);
    step(1'b1, 2'd3, 17'h8, '0, '0);
    check("R6 force", 32'(status), 32'h1777F);
    step(1'b1, 2'd3, 17'h4, '0, '0);
    step(1'b1, 2'd2, 17'h0, '0, '0);
    step(1'b1, 2'd0, 17'h1FFFF, '0, '0);

    // constrained random
    void'($urandom(32'd7731));
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  r = 4'($urandom_range(0, 15));
      logic [1:0]  s;
      logic [16:0] d = 17'($urandom());
      s = (r < 8) ? 2'd0 : (r < 12) ? 2'd1 : (r < 14) ? 2'd2 : 2'd3;
      step(($urandom_range(0, 3) != 0), s, d,
           4'($urandom()) & 4'($urandom()), 4'($urandom()) & 4'($urandom()));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule